// File: doc/BRIEF.md
# Posted-Command Bus Slave Buffer

This block is the slave end of a memory-mapped bus. It takes read and write commands into a queue instead of stalling the master while each one is carried out. Every queued entry records the command kind, the target address and, for writes, the data. A back end takes entries from the head of the queue, one per clock whenever `be_ready` is high. Writes go into a small register store. Reads return the addressed word.

Reads are split into two phases. The address phase ends when the command is accepted. The data phase comes later, marked by a one-cycle `bus_rvalid` strobe. Several reads can therefore be outstanding together, up to a parameterised limit. The master is held off only in two cases: the queue has no free slot, or one more read would exceed that limit.

Top module: `posted_cmd_slave`

## Requirements
- R1: While `rst_n` is low, `bus_waitreq` and `bus_rvalid` are low. After reset every register of the store reads back as zero.
- R2: A command is accepted in any cycle where `bus_read` or `bus_write` is high and `bus_waitreq` is low. When the queue has room, the master is not stalled.
- R3: When `DEPTH` commands are waiting, `bus_waitreq` is high. A command held by the master is accepted once a slot frees. No command is lost or duplicated.
- R4: With the queue empty and `be_ready` high, a read accepted in cycle k gives `bus_rvalid` high in cycle k+2, and low again in cycle k+3 unless another read follows.
- R5: Read responses come back in the order the reads were accepted, with exactly one `bus_rvalid` pulse per read.
- R6: Commands execute in acceptance order. A read that follows a write to the same address returns the written value, and a later write to an address replaces the earlier value.
- R7: A read is held off with `bus_waitreq` when `MAX_PEND` reads are outstanding and none of them retires in that cycle. Writes are still accepted in that state. A read response and a new read acceptance can fall in the same cycle, so a stream of reads runs at one per cycle.
- R8: When `bus_read` and `bus_write` are both high, the command is treated as a write and produces no read response.
- R9: While `be_ready` is low, no queued command executes and `bus_rvalid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Command address |
| bus_read | input | 1 | Read command request |
| bus_write | input | 1 | Write command request (wins over read) |
| bus_wdata | input | DATA_W | Write data |
| bus_waitreq | output | 1 | Hold-off: master must keep its command stable |
| bus_rdata | output | DATA_W | Read response data |
| bus_rvalid | output | 1 | One-cycle strobe marking a read response |
| be_ready | input | 1 | Back end may execute the head command this cycle |

## Verification
Two pairs of events can land on the same clock edge, and the tests provoke both. In the first, a read retires on `bus_rvalid` in the same cycle a new read is offered while the outstanding count sits at its limit. An uninterrupted stream of reads creates this case, and it is judged by counting zero stall cycles across the stream while every response matches the bench's own register model in order. In the second, a push and a pop hit the queue together. This is provoked by holding a write against a full queue, then raising `be_ready`. The test checks that the held write is taken only after the stall and that every queued value reads back exactly once.

// File: rtl/pcs_pkg.sv
// Shared definitions for the posted-command slave.
// Assumes nothing beyond elaboration-time constant evaluation.
package pcs_pkg;

    // Kind of a queued command; the stored bit is decoded by the executor.
    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // Index width for a structure of n entries, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pcs_cmd_fifo.sv
// Circular command queue of DEPTH entries, each W bits wide.
// Assumes: the caller pushes only when not full and pops only when not empty;
// both requests are also gated internally. DEPTH >= 1.
module pcs_cmd_fifo #(
    parameter int W     = 37,
    parameter int DEPTH = 4,
    localparam int PW   = pcs_pkg::idx_w(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    // Qualify requests against the current occupancy.
    always_comb begin
        do_push = push & ~full;
        do_pop  = pop & ~empty;
    end

    // Status flags from the occupancy count.
    always_comb begin
        empty    = (level == '0);
        full     = (level == CW'(DEPTH));
        pop_data = mem[rptr];
    end

    // Pointer advance with wrap at the last slot.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write, pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_data;
                wptr      <= step(wptr);
            end
            if (do_pop) begin
                rptr <= step(rptr);
            end
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/pcs_pend_ctr.sv
// Counts reads accepted but not yet answered and flags the limit.
// The limit flag ignores a slot that is being freed this same cycle, so a
// retiring response and a new read may coincide. Assumes MAX_PEND >= 1.
module pcs_pend_ctr #(
    parameter int MAX_PEND = 2,
    localparam int PCW     = $clog2(MAX_PEND + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_accept,
    input  logic           rsp_done,
    output logic [PCW-1:0] count,
    output logic           at_limit
);

    // Limit reached only if no response frees a slot now.
    always_comb begin
        at_limit = (count == PCW'(MAX_PEND)) & ~rsp_done;
    end

    // Outstanding-read bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + PCW'(rd_accept) - PCW'(rsp_done);
        end
    end

endmodule

// File: rtl/pcs_exec.sv
// Back-end executor: a register store of 2**AW words. One command per cycle
// when go is high; a write updates the store at that edge, a read registers
// the addressed word and raises rvalid for exactly the following cycle.
// Assumes commands arrive in acceptance order.
module pcs_exec #(
    parameter int AW   = 4,
    parameter int DW   = 32,
    localparam int NREG = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  pcs_pkg::op_e  op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] regs [NREG];

    // Store update on executed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (go && op == pcs_pkg::OP_WR) begin
            regs[addr] <= wdata;
        end
    end

    // Read response register and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= go && op == pcs_pkg::OP_RD;
            if (go && op == pcs_pkg::OP_RD) begin
                rdata <= regs[addr];
            end
        end
    end

endmodule

// File: rtl/posted_cmd_slave.sv
// Posted-command bus slave: accepts reads and writes into a queue without
// stalling, executes them in order against a register store, and returns
// read data on a separate one-cycle valid strobe.
// Assumes the master keeps its command stable while bus_waitreq is high.
module posted_cmd_slave #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 4,
    parameter int MAX_PEND = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_read,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_waitreq,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              be_ready
);

    localparam int CMD_W = 1 + ADDR_W + DATA_W;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int PCW   = $clog2(MAX_PEND + 1);

    logic              fifo_full;
    logic              fifo_empty;
    logic [LW-1:0]     fifo_level;
    logic [CMD_W-1:0]  push_word;
    logic [CMD_W-1:0]  head_word;
    logic              accept;
    logic              accept_rd;
    logic              pop;
    logic              pend_at_limit;
    logic [PCW-1:0]    pend_count;
    pcs_pkg::op_e      head_op;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;

    // Hold-off and acceptance decode; write wins when both requests are high.
    always_comb begin
        bus_waitreq = fifo_full | (bus_read & ~bus_write & pend_at_limit);
        accept      = (bus_read | bus_write) & ~bus_waitreq;
        accept_rd   = accept & ~bus_write;
        push_word   = {bus_write, bus_addr, bus_wdata};
    end

    // Head-of-queue decode and drain request.
    always_comb begin
        head_op   = pcs_pkg::op_e'(head_word[CMD_W-1]);
        head_addr = head_word[CMD_W-2 -: ADDR_W];
        head_data = head_word[DATA_W-1:0];
        pop       = ~fifo_empty & be_ready;
    end

    pcs_cmd_fifo #(
        .W     (CMD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (push_word),
        .pop       (pop),
        .pop_data  (head_word),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_level)
    );

    pcs_pend_ctr #(
        .MAX_PEND (MAX_PEND)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_accept (accept_rd),
        .rsp_done  (bus_rvalid),
        .count     (pend_count),
        .at_limit  (pend_at_limit)
    );

    pcs_exec #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (pop),
        .op     (head_op),
        .addr   (head_addr),
        .wdata  (head_data),
        .rvalid (bus_rvalid),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/pcs_checker.sv
// Property checker for posted_cmd_slave, attached by bind below.
// Observes ports plus queue occupancy and outstanding-read count.
module pcs_checker #(
    parameter int DEPTH    = 4,
    parameter int MAX_PEND = 2,
    localparam int LW      = $clog2(DEPTH + 1),
    localparam int PCW     = $clog2(MAX_PEND + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_read,
    input logic           bus_write,
    input logic           bus_waitreq,
    input logic           bus_rvalid,
    input logic           be_ready,
    input logic [LW-1:0]  fifo_level,
    input logic [PCW-1:0] pend_count
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_rvalid && fifo_level == '0 && pend_count == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    // R3
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LW'(DEPTH)) |-> bus_waitreq);

    // R7
    pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count <= PCW'(MAX_PEND));

    // R7
    rd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == PCW'(MAX_PEND) && !bus_rvalid && bus_read && !bus_write)
            |-> bus_waitreq);

    // R5
    rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (pend_count != '0));

    // R9
    idle_backend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(be_ready) |-> !bus_rvalid);

endmodule

bind posted_cmd_slave pcs_checker #(
    .DEPTH    (DEPTH),
    .MAX_PEND (MAX_PEND)
) u_pcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_read    (bus_read),
    .bus_write   (bus_write),
    .bus_waitreq (bus_waitreq),
    .bus_rvalid  (bus_rvalid),
    .be_ready    (be_ready),
    .fifo_level  (fifo_level),
    .pend_count  (pend_count)
);

// File: tb/posted_cmd_slave_test.sv
`timescale 1ns/1ps
module posted_cmd_slave_test;

    localparam int AW    = 4;
    localparam int DW    = 32;
    localparam int DEPTH = 4;
    localparam int MAXP  = 2;
    localparam int NVEC  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_read = 1'b0;
    logic          bus_write = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_waitreq;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic          be_ready = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int stalls  = 0;
    int n_rsp   = 0;
    int q_wr    = 0;
    int q_rd    = 0;
    bit done    = 1'b0;
    logic [DW-1:0] exp_q [256];
    logic [DW-1:0] mdl [16];

    // Vector: {write, addr[3:0], wdata[31:0], expected read data[31:0]}
    localparam logic [68:0] VEC [NVEC] = '{
        {1'b0, 4'd3,  32'h0,         32'h0},
        {1'b1, 4'd3,  32'hA5A5_0001, 32'h0},
        {1'b0, 4'd3,  32'h0,         32'hA5A5_0001},
        {1'b1, 4'd7,  32'h1234_5678, 32'h0},
        {1'b1, 4'd7,  32'hCAFE_0007, 32'h0},
        {1'b0, 4'd7,  32'h0,         32'hCAFE_0007},
        {1'b0, 4'd3,  32'h0,         32'hA5A5_0001},
        {1'b1, 4'd15, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd15, 32'h0,         32'hFFFF_FFFF},
        {1'b0, 4'd0,  32'h0,         32'h0},
        {1'b1, 4'd0,  32'h0000_0042, 32'h0},
        {1'b0, 4'd0,  32'h0,         32'h0000_0042}
    };

    posted_cmd_slave #(
        .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .MAX_PEND(MAXP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_read(bus_read),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .be_ready(be_ready)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one command, wait out any hold-off, record the accepted effect.
    task automatic bus_op(input bit wr, input bit rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] e);
        @(negedge clk);
        bus_write = wr; bus_read = rd; bus_addr = a; bus_wdata = d;
        #1;
        while (bus_waitreq) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        if (wr) mdl[a] = d;
        else begin exp_q[q_wr] = e; q_wr++; end
        #1;
        bus_write = 1'b0; bus_read = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // Response monitor: in-order data against the bench's expectation queue.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_rsp++;
            if (q_rd < q_wr) begin
                chk(bus_rdata == exp_q[q_rd], "R5/R6 ordered read data", bus_rdata, exp_q[q_rd]);
                q_rd++;
            end else begin
                chk(1'b0, "R5 response with no read outstanding", 32'(n_rsp), 32'(q_wr));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int s0;
        int r0;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_waitreq, "R1 waitreq low in reset", 32'(bus_waitreq), 0);
        chk(!bus_rvalid, "R1 rvalid low in reset", 32'(bus_rvalid), 0);
        rst_n = 1'b1;

        // Table walk: R1 zero after reset, R2 acceptance, R6 read-after-write.
        s0 = stalls;
        for (int i = 0; i < NVEC; i++) begin
            bus_op(VEC[i][68], !VEC[i][68], VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);
        end
        chk(stalls == s0, "R2 no stall with free space", 32'(stalls - s0), 0);
        settle();
        chk(q_rd == q_wr, "R5 every read answered", 32'(q_rd), 32'(q_wr));

        // R4 response timing on an idle queue.
        bus_op(1'b0, 1'b1, 4'd7, 0, mdl[7]);
        @(negedge clk);
        chk(!bus_rvalid, "R4 no strobe at k+1", 32'(bus_rvalid), 0);
        @(negedge clk);
        chk(bus_rvalid, "R4 strobe at k+2", 32'(bus_rvalid), 1);
        @(negedge clk);
        chk(!bus_rvalid, "R4 strobe lasts one cycle", 32'(bus_rvalid), 0);

        // R3 / R9: stalled back end fills the queue.
        @(negedge clk);
        be_ready = 1'b0;
        r0 = n_rsp;
        for (int i = 0; i < DEPTH; i++) begin
            bus_op(1'b1, 1'b0, AW'(8 + i), 32'h100 + 32'(i), 0);
        end
        repeat (3) @(negedge clk);
        chk(n_rsp == r0, "R9 nothing executes while back end idle", 32'(n_rsp), 32'(r0));
        @(negedge clk);
        bus_write = 1'b1; bus_addr = 4'd12; bus_wdata = 32'h200;
        #1;
        chk(bus_waitreq, "R3 waitreq when full", 32'(bus_waitreq), 1);
        s0 = stalls;
        fork
            bus_op(1'b1, 1'b0, 4'd12, 32'h200, 0);
            begin
                repeat (5) @(negedge clk);
                be_ready = 1'b1;
            end
        join
        chk(stalls - s0 >= 4, "R3 held until space", 32'(stalls - s0), 4);
        for (int i = 8; i < 13; i++) begin
            bus_op(1'b0, 1'b1, AW'(i), 0, mdl[i]);
        end
        settle();
        chk(q_rd == q_wr, "R3 no command lost", 32'(q_rd), 32'(q_wr));

        // R7: pending-read limit blocks reads but not writes.
        @(negedge clk);
        be_ready = 1'b0;
        bus_op(1'b0, 1'b1, 4'd8, 0, mdl[8]);
        bus_op(1'b0, 1'b1, 4'd9, 0, mdl[9]);
        @(negedge clk);
        bus_read = 1'b1; bus_addr = 4'd10;
        #1;
        chk(bus_waitreq, "R7 read held at limit", 32'(bus_waitreq), 1);
        bus_read = 1'b0; bus_write = 1'b1; bus_addr = 4'd9; bus_wdata = 32'h999;
        #1;
        chk(!bus_waitreq, "R7 write accepted at limit", 32'(bus_waitreq), 0);
        @(posedge clk);
        mdl[9] = 32'h999;
        #1;
        bus_write = 1'b0;
        @(negedge clk);
        be_ready = 1'b1;
        bus_op(1'b0, 1'b1, 4'd9, 0, mdl[9]);
        settle();
        chk(q_rd == q_wr, "R7 reads drained after limit", 32'(q_rd), 32'(q_wr));

        // R8: read and write together act as a write.
        r0 = n_rsp;
        bus_op(1'b1, 1'b1, 4'd5, 32'h55, 0);
        settle();
        chk(n_rsp == r0, "R8 no response for combined request", 32'(n_rsp), 32'(r0));
        bus_op(1'b0, 1'b1, 4'd5, 0, 32'h55);
        settle();
        chk(q_rd == q_wr, "R8 combined request wrote data", 32'(q_rd), 32'(q_wr));

        // R7 same-cycle retire and accept: read stream runs without stalls.
        s0 = stalls;
        r0 = n_rsp;
        for (int i = 0; i < 8; i++) begin
            bus_op(1'b0, 1'b1, AW'(i * 3), 0, mdl[(i * 3) % 16]);
        end
        chk(stalls == s0, "R7 read stream at one per cycle", 32'(stalls - s0), 0);
        settle();
        chk(n_rsp - r0 == 8, "R5 one strobe per read", 32'(n_rsp - r0), 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule